// File: doc/BRIEF.md
# Legacy Keyboard Controller Emulation Unit

This unit lets a host controller stand in for an old keyboard controller. Software programs it through a small register window. The window holds a control word, an input byte, an output byte and a status byte. The unit watches host accesses to the data port (60h) and the command port (64h). When emulation is on, it traps those accesses. It stores what the host wrote and follows the two-step command that sets the A20 gate. It keeps edge-triggered flags for the two interrupt lines of the real keyboard controller.

From this state it drives two legacy interrupt lines and one emulation interrupt. The legacy lines are the keyboard line and the auxiliary (mouse) line. The emulation interrupt wakes the emulation software. All three outputs are combinational decodes of stored state, so they change in the cycle right after the state changes. Register reads and port reads return their data in the same cycle as the request.

Top module: `kbc_emu_top`

## Requirements
- R1: After a synchronous reset, every register reads zero and `irq1_out`, `irq12_out` and `emu_irq` are 0.
- R2: Register reads are combinational. The registers sit at window offsets control 100h, input 104h, output 108h and status 10Ch; any other address reads zero. Control bit layout: bit 0 emulation enable, bit 1 emulation interrupt (read-only, equal to `emu_irq`), bit 2 character-pending enable, bit 3 legacy-IRQ enable, bit 4 external-IRQ enable, bit 5 A20 command in progress (read-only), bit 6 keyboard IRQ seen, bit 7 auxiliary IRQ seen, bit 8 A20 state. Bits 31..9 read zero. Input, output and status use bits 7..0.
- R3: A 0-to-1 change on `kbd_irq1_in` sets control bit 6 at the next clock edge, and one on `kbd_irq12_in` sets bit 7. A level held high does not set the bit again.
- R4: Writing 1 to control bit 6 or bit 7 clears it, and writing 0 leaves it as it is. If a new rising edge arrives in the same cycle, the bit stays set.
- R5: If external-IRQ enable is 1 and either seen-bit is set, `emu_irq` is 1, whatever the value of emulation enable.
- R6: If legacy-IRQ enable is 1 and status bit 0 (output full) is 1, `irq1_out` follows status bit 5 = 0 and `irq12_out` follows status bit 5 = 1. Otherwise both are 0. The two are never 1 together.
- R7: If emulation enable and character-pending enable are both 1 and status bit 0 is 0, `emu_irq` is 1.
- R8: While emulation is enabled, a port 64h write of D1h sets control bit 5. A port 64h write of any other value clears it, and so does any port 60h write.
- R9: Port 60h write while bit 5 is set:
  - If data bit 1 equals the A20 state, the write is silent: Input Full is left unchanged and no trap is raised.
  - If data bit 1 differs from the A20 state, a trap is raised.
- R10: While emulation is enabled, a port write stores its byte in the input register and sets Input Full (status bit 1). The one exception is the silent match in R9. A port 64h write also sets status bit 3, and a port 60h write clears it.
- R11: A trap is raised by any port 64h write, or by a mismatching 60h write during the A20 command. A raised trap holds `emu_irq` at 1 while emulation is enabled, until status bit 1 is 0. Software makes it 0 by writing the status register.
- R12: While emulation is enabled, a port 60h read returns the output register on `port_rdata` and clears status bit 0. A port 64h read returns the status register. Any other port read returns zero.
- R13: While emulation is disabled, port accesses change no state and `port_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| port_addr | input | 8 | Host I/O port address |
| port_wdata | input | 8 | Host I/O write byte |
| port_wr | input | 1 | Host I/O write strobe |
| port_rd | input | 1 | Host I/O read strobe |
| port_rdata | output | 8 | Host I/O read byte (combinational) |
| kbd_irq1_in | input | 1 | Keyboard IRQ line from the real controller |
| kbd_irq12_in | input | 1 | Auxiliary IRQ line from the real controller |
| irq1_out | output | 1 | Legacy keyboard interrupt |
| irq12_out | output | 1 | Legacy auxiliary interrupt |
| emu_irq | output | 1 | Emulation interrupt |

## Verification
The assertions check these rules on every cycle:
- the two legacy interrupt lines are never active together;
- a rising IRQ edge is latched;
- a write-1 clear works;
- the D1h command sets the A20 flag and any other command value clears it;
- a seen-bit raises the emulation interrupt through external-IRQ enable;
- a port write while emulation is disabled leaves the input register unchanged.

Some behaviour needs the bench's scenarios and its reference model:
- the silent versus trapping end of the A20 command;
- the trap staying active until Input Full is cleared;
- port read data;
- character-pending interrupts;
- the full register readback under random interleaving of register and port traffic.

// File: rtl/kbc_emu_pkg.sv
package kbc_emu_pkg;

    localparam int REG_W  = 32;
    localparam int BYTE_W = 8;
    localparam int OFF_W  = 4;           // 16-byte register window
    localparam int NUM_EXT_IRQ = 2;      // index 0: keyboard, 1: auxiliary

    // control word bit positions
    localparam int CB_EMU_EN  = 0;
    localparam int CB_EMU_IRQ = 1;
    localparam int CB_CP_EN   = 2;
    localparam int CB_IRQ_EN  = 3;
    localparam int CB_EXT_EN  = 4;
    localparam int CB_A20_SEQ = 5;
    localparam int CB_SEEN1   = 6;
    localparam int CB_SEEN12  = 7;
    localparam int CB_A20     = 8;

    // status byte bit positions
    localparam int SB_OBF = 0;
    localparam int SB_IBF = 1;
    localparam int SB_CMD = 3;
    localparam int SB_AUX = 5;

    localparam logic [BYTE_W-1:0] A20_CMD = 8'hD1;

    typedef enum logic [1:0] {
        RSEL_CTRL = 2'd0,
        RSEL_IN   = 2'd1,
        RSEL_OUT  = 2'd2,
        RSEL_STAT = 2'd3
    } rsel_e;

    typedef struct packed {
        logic emu_en;
        logic cp_en;
        logic irq_en;
        logic ext_en;
        logic a20;
    } ctrl_cfg_t;

    typedef struct packed {
        logic wr_data;
        logic wr_cmd;
        logic rd_data;
        logic rd_cmd;
    } port_ev_t;

    function automatic logic [REG_W-1:0] ctrl_word(
        input ctrl_cfg_t cfg,
        input logic [NUM_EXT_IRQ-1:0] seen,
        input logic seq,
        input logic emu
    );
        logic [REG_W-1:0] w;
        w = '0;
        w[CB_EMU_EN]  = cfg.emu_en;
        w[CB_EMU_IRQ] = emu;
        w[CB_CP_EN]   = cfg.cp_en;
        w[CB_IRQ_EN]  = cfg.irq_en;
        w[CB_EXT_EN]  = cfg.ext_en;
        w[CB_A20_SEQ] = seq;
        w[CB_SEEN1]   = seen[0];
        w[CB_SEEN12]  = seen[1];
        w[CB_A20]     = cfg.a20;
        return w;
    endfunction

endpackage

// File: rtl/kbc_edge_latch.sv
module kbc_edge_latch #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lines,
    input  logic [N-1:0] clr,
    output logic [N-1:0] seen
);
    for (genvar i = 0; i < N; i++) begin : g_line
        logic prev_q;
        logic seen_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                prev_q <= 1'b0;
                seen_q <= 1'b0;
            end else begin
                prev_q <= lines[i];
                // a new edge wins over a simultaneous clear
                seen_q <= (lines[i] & ~prev_q) | (seen_q & ~clr[i]);
            end
        end
        assign seen[i] = seen_q;
    end
endmodule

// File: rtl/kbc_port_trap.sv
module kbc_port_trap import kbc_emu_pkg::*; #(
    parameter logic [7:0] DATA_PORT = 8'h60,
    parameter logic [7:0] CMD_PORT  = 8'h64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              emu_en,
    input  logic              a20,
    input  logic [7:0]        port_addr,
    input  logic [BYTE_W-1:0] port_wdata,
    input  logic              port_wr,
    input  logic              port_rd,
    output port_ev_t          ev,
    output logic              seq,
    output logic              trap_ev,
    output logic              silent
);
    logic seq_q;
    logic is_data, is_cmd;

    assign is_data = emu_en && (port_addr == DATA_PORT);
    assign is_cmd  = emu_en && (port_addr == CMD_PORT);

    always_comb begin
        ev.wr_data = is_data && port_wr;
        ev.wr_cmd  = is_cmd  && port_wr;
        ev.rd_data = is_data && port_rd;
        ev.rd_cmd  = is_cmd  && port_rd;
    end

    assign silent  = ev.wr_data && seq_q && (port_wdata[1] == a20);
    assign trap_ev = ev.wr_cmd || (ev.wr_data && seq_q && (port_wdata[1] != a20));

    always_ff @(posedge clk) begin
        if (rst)
            seq_q <= 1'b0;
        else if (ev.wr_cmd)
            seq_q <= (port_wdata == A20_CMD);
        else if (ev.wr_data)
            seq_q <= 1'b0;
    end

    assign seq = seq_q;
endmodule

// File: rtl/kbc_irq_gen.sv
module kbc_irq_gen import kbc_emu_pkg::*; (
    input  ctrl_cfg_t             cfg,
    input  logic [NUM_EXT_IRQ-1:0] seen,
    input  logic [BYTE_W-1:0]     stat,
    input  logic                  trap,
    output logic                  irq1,
    output logic                  irq12,
    output logic                  emu
);
    logic legacy;
    assign legacy = cfg.irq_en && stat[SB_OBF];
    assign irq1   = legacy && !stat[SB_AUX];
    assign irq12  = legacy &&  stat[SB_AUX];
    assign emu    = (cfg.ext_en && (|seen))
                  || (cfg.emu_en && cfg.cp_en && !stat[SB_OBF])
                  || (cfg.emu_en && trap);
endmodule

// File: rtl/kbc_emu_top.sv
module kbc_emu_top import kbc_emu_pkg::*; #(
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 'h100,
    parameter logic [7:0]        DATA_PORT = 8'h60,
    parameter logic [7:0]        CMD_PORT  = 8'h64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [7:0]        port_addr,
    input  logic [BYTE_W-1:0] port_wdata,
    input  logic              port_wr,
    input  logic              port_rd,
    output logic [BYTE_W-1:0] port_rdata,
    input  logic              kbd_irq1_in,
    input  logic              kbd_irq12_in,
    output logic              irq1_out,
    output logic              irq12_out,
    output logic              emu_irq
);
    ctrl_cfg_t              cfg_q;
    logic [BYTE_W-1:0]      in_q, out_q, stat_q, stat_nxt;
    logic                   trap_q, trap_nxt;
    logic [NUM_EXT_IRQ-1:0] seen, seen_clr;
    logic                   seq_q, trap_ev, silent;
    port_ev_t               ev;
    logic                   hit;
    rsel_e                  rsel;
    logic                   wr_ctrl, wr_in, wr_out, wr_stat;
    logic                   unused_ok;

    // register window decode
    assign hit  = (reg_addr[ADDR_W-1:OFF_W] == WIN_BASE[ADDR_W-1:OFF_W]) && (reg_addr[1:0] == 2'b00);
    assign rsel = rsel_e'(reg_addr[3:2]);
    assign wr_ctrl = reg_wr && hit && (rsel == RSEL_CTRL);
    assign wr_in   = reg_wr && hit && (rsel == RSEL_IN);
    assign wr_out  = reg_wr && hit && (rsel == RSEL_OUT);
    assign wr_stat = reg_wr && hit && (rsel == RSEL_STAT);

    assign seen_clr = {wr_ctrl && reg_wdata[CB_SEEN12], wr_ctrl && reg_wdata[CB_SEEN1]};

    kbc_edge_latch #(.N(NUM_EXT_IRQ)) u_edge (
        .clk   (clk),
        .rst   (rst),
        .lines ({kbd_irq12_in, kbd_irq1_in}),
        .clr   (seen_clr),
        .seen  (seen)
    );

    kbc_port_trap #(.DATA_PORT(DATA_PORT), .CMD_PORT(CMD_PORT)) u_trap (
        .clk        (clk),
        .rst        (rst),
        .emu_en     (cfg_q.emu_en),
        .a20        (cfg_q.a20),
        .port_addr  (port_addr),
        .port_wdata (port_wdata),
        .port_wr    (port_wr),
        .port_rd    (port_rd),
        .ev         (ev),
        .seq        (seq_q),
        .trap_ev    (trap_ev),
        .silent     (silent)
    );

    kbc_irq_gen u_irq (
        .cfg   (cfg_q),
        .seen  (seen),
        .stat  (stat_q),
        .trap  (trap_q),
        .irq1  (irq1_out),
        .irq12 (irq12_out),
        .emu   (emu_irq)
    );

    // status: software write first, port side effects on top
    always_comb begin
        stat_nxt = wr_stat ? reg_wdata[BYTE_W-1:0] : stat_q;
        if (ev.wr_cmd) begin
            stat_nxt[SB_CMD] = 1'b1;
            stat_nxt[SB_IBF] = 1'b1;
        end
        if (ev.wr_data) begin
            stat_nxt[SB_CMD] = 1'b0;
            if (!silent)
                stat_nxt[SB_IBF] = 1'b1;
        end
        if (ev.rd_data)
            stat_nxt[SB_OBF] = 1'b0;
    end

    assign trap_nxt = trap_ev || (trap_q && stat_nxt[SB_IBF]);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            in_q   <= '0;
            out_q  <= '0;
            stat_q <= '0;
            trap_q <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                cfg_q.emu_en <= reg_wdata[CB_EMU_EN];
                cfg_q.cp_en  <= reg_wdata[CB_CP_EN];
                cfg_q.irq_en <= reg_wdata[CB_IRQ_EN];
                cfg_q.ext_en <= reg_wdata[CB_EXT_EN];
                cfg_q.a20    <= reg_wdata[CB_A20];
            end
            if (ev.wr_data || ev.wr_cmd)
                in_q <= port_wdata;
            else if (wr_in)
                in_q <= reg_wdata[BYTE_W-1:0];
            if (wr_out)
                out_q <= reg_wdata[BYTE_W-1:0];
            stat_q <= stat_nxt;
            trap_q <= trap_nxt;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (hit) begin
            unique case (rsel)
                RSEL_CTRL: reg_rdata = ctrl_word(cfg_q, seen, seq_q, emu_irq);
                RSEL_IN:   reg_rdata[BYTE_W-1:0] = in_q;
                RSEL_OUT:  reg_rdata[BYTE_W-1:0] = out_q;
                RSEL_STAT: reg_rdata[BYTE_W-1:0] = stat_q;
            endcase
        end
    end

    always_comb begin
        if (ev.rd_data)
            port_rdata = out_q;
        else if (ev.rd_cmd)
            port_rdata = stat_q;
        else
            port_rdata = '0;
    end

    assign unused_ok = ^{reg_wdata[REG_W-1:CB_A20+1], reg_wdata[CB_A20_SEQ], reg_wdata[CB_EMU_IRQ]};
endmodule

// File: rtl/kbc_emu_chk.sv
module kbc_emu_chk import kbc_emu_pkg::*; #(
    parameter logic [7:0] DATA_PORT = 8'h60,
    parameter logic [7:0] CMD_PORT  = 8'h64
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   kbd_irq1_in,
    input logic                   irq1_out,
    input logic                   irq12_out,
    input logic                   emu_irq,
    input logic                   wr_ctrl,
    input logic                   wr_in,
    input logic [REG_W-1:0]       reg_wdata,
    input logic [NUM_EXT_IRQ-1:0] seen,
    input ctrl_cfg_t              cfg_q,
    input logic                   port_wr,
    input logic [7:0]             port_addr,
    input logic [BYTE_W-1:0]      port_wdata,
    input logic                   seq_q,
    input logic [BYTE_W-1:0]      in_q
);
    assert_legacy_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        !(irq1_out && irq12_out));

    assert_edge_latched_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(kbd_irq1_in) |=> seen[0]);

    assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && reg_wdata[CB_SEEN1] && !kbd_irq1_in) |=> !seen[0]);

    assert_ext_irq_emu_R5: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.ext_en && (|seen)) |-> emu_irq);

    assert_a20_cmd_set_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.emu_en && port_wr && port_addr == CMD_PORT && port_wdata == A20_CMD) |=> seq_q);

    assert_a20_cmd_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.emu_en && port_wr && port_addr == CMD_PORT && port_wdata != A20_CMD) |=> !seq_q);

    assert_disabled_port_ignored_R13: assert property (@(posedge clk) disable iff (rst)
        (!cfg_q.emu_en && port_wr && !wr_in) |=> $stable(in_q));

    logic unused_chk;
    assign unused_chk = ^{DATA_PORT, cfg_q.cp_en, cfg_q.irq_en, cfg_q.a20};
endmodule

bind kbc_emu_top kbc_emu_chk #(.DATA_PORT(DATA_PORT), .CMD_PORT(CMD_PORT)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .kbd_irq1_in (kbd_irq1_in),
    .irq1_out    (irq1_out),
    .irq12_out   (irq12_out),
    .emu_irq     (emu_irq),
    .wr_ctrl     (wr_ctrl),
    .wr_in       (wr_in),
    .reg_wdata   (reg_wdata),
    .seen        (seen),
    .cfg_q       (cfg_q),
    .port_wr     (port_wr),
    .port_addr   (port_addr),
    .port_wdata  (port_wdata),
    .seq_q       (seq_q),
    .in_q        (in_q)
);

// File: tb/sim_kbc_emu_top.sv
module sim_kbc_emu_top;
    localparam time CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic [11:0] reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [7:0]  port_addr, port_wdata, port_rdata;
    logic        port_wr, port_rd;
    logic        i1, i12;
    logic        irq1_out, irq12_out, emu_irq;

    int n_cmp = 0;
    int n_bad = 0;

    // reference model state
    logic m_en, m_cp, m_ie, m_xe, m_a20, m_a1, m_a12, m_seq, m_trap, m_p1, m_p12;
    logic [7:0] m_in, m_out, m_st;

    always #(CLK_PERIOD/2) clk = ~clk;

    kbc_emu_top u0 (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .port_addr(port_addr), .port_wdata(port_wdata), .port_wr(port_wr), .port_rd(port_rd),
        .port_rdata(port_rdata),
        .kbd_irq1_in(i1), .kbd_irq12_in(i12),
        .irq1_out(irq1_out), .irq12_out(irq12_out), .emu_irq(emu_irq)
    );

    function automatic logic exp_emu();
        return (m_xe && (m_a1 || m_a12)) || (m_en && m_cp && !m_st[0]) || (m_en && m_trap);
    endfunction

    function automatic logic [31:0] exp_reg(input logic [11:0] a);
        case (a)
            12'h100: return {23'b0, m_a20, m_a12, m_a1, m_seq, m_xe, m_ie, m_cp, exp_emu(), m_en};
            12'h104: return {24'b0, m_in};
            12'h108: return {24'b0, m_out};
            12'h10C: return {24'b0, m_st};
            default: return 32'b0;
        endcase
    endfunction

    function automatic logic [7:0] exp_port();
        if (!m_en || !port_rd) return 8'h00;
        if (port_addr == 8'h60) return m_out;
        if (port_addr == 8'h64) return m_st;
        return 8'h00;
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        {m_en, m_cp, m_ie, m_xe, m_a20, m_a1, m_a12, m_seq, m_trap, m_p1, m_p12} = '0;
        m_in = '0; m_out = '0; m_st = '0;
    endtask

    task automatic model_clock();
        logic wc, wi, wo, ws, pw60, pw64, pr60, sil, tev;
        logic [7:0] st_n;
        wc   = reg_wr && reg_addr == 12'h100;
        wi   = reg_wr && reg_addr == 12'h104;
        wo   = reg_wr && reg_addr == 12'h108;
        ws   = reg_wr && reg_addr == 12'h10C;
        pw60 = m_en && port_wr && port_addr == 8'h60;
        pw64 = m_en && port_wr && port_addr == 8'h64;
        pr60 = m_en && port_rd && port_addr == 8'h60;
        sil  = pw60 && m_seq && (port_wdata[1] == m_a20);
        tev  = pw64 || (pw60 && m_seq && (port_wdata[1] != m_a20));
        st_n = ws ? reg_wdata[7:0] : m_st;
        if (pw64) begin st_n[3] = 1'b1; st_n[1] = 1'b1; end
        if (pw60) begin st_n[3] = 1'b0; if (!sil) st_n[1] = 1'b1; end
        if (pr60) st_n[0] = 1'b0;
        m_a1  = (i1 && !m_p1) || (m_a1 && !(wc && reg_wdata[6]));
        m_a12 = (i12 && !m_p12) || (m_a12 && !(wc && reg_wdata[7]));
        m_p1 = i1; m_p12 = i12;
        if (pw64) m_seq = (port_wdata == 8'hD1);
        else if (pw60) m_seq = 1'b0;
        if (pw60 || pw64) m_in = port_wdata;
        else if (wi) m_in = reg_wdata[7:0];
        if (wo) m_out = reg_wdata[7:0];
        m_trap = tev || (m_trap && st_n[1]);
        m_st = st_n;
        if (wc) begin
            m_en = reg_wdata[0]; m_cp = reg_wdata[2]; m_ie = reg_wdata[3];
            m_xe = reg_wdata[4]; m_a20 = reg_wdata[8];
        end
    endtask

    // inputs are driven just after a falling edge; compare, then clock the model
    task automatic step(input string tag);
        #1;
        check(tag, "reg_rdata", reg_rdata, exp_reg(reg_addr));
        check(tag, "port_rdata", {24'b0, port_rdata}, {24'b0, exp_port()});
        check(tag, "irq1_out", {31'b0, irq1_out}, {31'b0, m_ie && m_st[0] && !m_st[5]});
        check(tag, "irq12_out", {31'b0, irq12_out}, {31'b0, m_ie && m_st[0] && m_st[5]});
        check(tag, "emu_irq", {31'b0, emu_irq}, {31'b0, exp_emu()});
        @(posedge clk);
        model_clock();
        @(negedge clk);
    endtask

    task automatic idle();
        reg_wr = 0; port_wr = 0; port_rd = 0;
    endtask

    task automatic rw(input logic [11:0] a, input logic [31:0] d);
        idle(); reg_wr = 1; reg_addr = a; reg_wdata = d;
    endtask

    task automatic pw(input logic [7:0] a, input logic [7:0] d, input logic [11:0] view);
        idle(); port_wr = 1; port_addr = a; port_wdata = d; reg_addr = view;
    endtask

    task automatic pr(input logic [7:0] a, input logic [11:0] view);
        idle(); port_rd = 1; port_addr = a; reg_addr = view;
    endtask

    task automatic look(input logic [11:0] a, input string tag);
        idle(); reg_addr = a; step(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'h5EED_0C17;
        void'($urandom(seed));
        rst = 1; idle(); reg_addr = '0; reg_wdata = '0; port_addr = '0; port_wdata = '0;
        i1 = 0; i12 = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1: reset values
        look(12'h100, "R1"); look(12'h104, "R1"); look(12'h108, "R1"); look(12'h10C, "R1");
        // R2: unmapped and misaligned addresses
        look(12'h110, "R2"); look(12'h102, "R2");
        // R13: disabled port write ignored
        pw(8'h60, 8'h5A, 12'h104); step("R13");
        pw(8'h64, 8'hD1, 12'h100); step("R13");
        look(12'h104, "R13"); look(12'h100, "R13");
        // enable emulation
        rw(12'h100, 32'h1); step("R2");
        // R8 / R9 silent match (A20 state 0, data bit1 = 0)
        pw(8'h64, 8'hD1, 12'h100); step("R8");
        look(12'h100, "R8");
        rw(12'h10C, 32'h0); step("R11");
        pw(8'h60, 8'hDD, 12'h10C); step("R9");
        look(12'h10C, "R9"); look(12'h100, "R9");
        // R9 mismatch -> trap, R11 clears via status write
        pw(8'h64, 8'hD1, 12'h100); step("R8");
        rw(12'h10C, 32'h0); step("R11");
        pw(8'h60, 8'hDF, 12'h104); step("R9");
        look(12'h100, "R9"); look(12'h10C, "R10");
        rw(12'h10C, 32'h0); step("R11");
        look(12'h100, "R11");
        // R8 other value clears sequence
        pw(8'h64, 8'hD1, 12'h100); step("R8");
        pw(8'h64, 8'hAA, 12'h100); step("R8");
        look(12'h100, "R8");
        // R6 legacy select
        rw(12'h100, 32'h9); step("R6");
        rw(12'h10C, 32'h01); step("R6"); look(12'h10C, "R6");
        rw(12'h10C, 32'h21); step("R6"); look(12'h10C, "R6");
        // R12 port reads
        rw(12'h108, 32'hA5); step("R12");
        pr(8'h64, 12'h10C); step("R12");
        pr(8'h60, 12'h10C); step("R12");
        look(12'h10C, "R12");
        pr(8'h61, 12'h10C); step("R12");
        // R7 character pending
        rw(12'h100, 32'h5); step("R7"); look(12'h100, "R7");
        rw(12'h10C, 32'h01); step("R7"); look(12'h100, "R7");
        // R3 / R5 / R4 with emulation disabled
        rw(12'h100, 32'h10); step("R5");
        idle(); i1 = 1; step("R3"); look(12'h100, "R3");
        look(12'h100, "R3");
        rw(12'h100, 32'h50); step("R4"); look(12'h100, "R4");
        idle(); i12 = 1; step("R3");
        rw(12'h100, 32'h90); i12 = 0; step("R4"); look(12'h100, "R5");
        i12 = 1; rw(12'h100, 32'h90); step("R4"); look(12'h100, "R4");
        i1 = 0; i12 = 0;
        rw(12'h100, 32'hC0); step("R4");

        // constrained random mix
        for (int n = 0; n < 4000; n++) begin
            int unsigned r;
            idle();
            r = $urandom_range(0, 6);
            case (r)
                0: reg_addr = 12'h100; 1: reg_addr = 12'h104; 2: reg_addr = 12'h108;
                3: reg_addr = 12'h10C; 4: reg_addr = 12'h110; 5: reg_addr = 12'h0FC;
                default: reg_addr = 12'h106;
            endcase
            reg_wr = ($urandom_range(0, 9) < 3);
            reg_wdata = $urandom();
            if (reg_addr == 12'h100 && $urandom_range(0, 9) < 8) reg_wdata[0] = 1'b1;
            r = $urandom_range(0, 3);
            port_addr = (r == 0) ? 8'h61 : (r == 1) ? 8'h64 : 8'h60;
            port_wdata = ($urandom_range(0, 3) == 0) ? 8'hD1 : 8'($urandom());
            port_wr = ($urandom_range(0, 9) < 3);
            port_rd = ($urandom_range(0, 9) < 2);
            if ($urandom_range(0, 7) == 0) i1 = ~i1;
            if ($urandom_range(0, 7) == 0) i12 = ~i12;
            step("R10");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule